// File: doc/BRIEF.md
# Slave Port Arbiter with Idle Parking

This block decides which of several bus masters owns one slave port of a multi-layer interconnect. Each master raises a request line; the slave side pulses an end-of-access strobe when the current transfer completes. The arbiter drives a one-hot grant vector, together with the encoded owner index and a flag that says whether any master is connected.

When a transfer ends and no master is asking for the port, the arbiter parks the grant instead of dropping it. A small configuration register, written through a simple write port, selects the parking policy. The port can disconnect, stay with the master that used it most recently, or move to a master named by software. A master that finds the port parked on itself starts its access at once, with no arbitration cycle. When several masters compete, a round-robin search starting just after the previous owner picks the winner.

Top module: `park_arbiter`

## Requirements
- R1: After reset, the grant vector is all zero, the grant valid flag is low, the policy is "none", the fixed master is 0 and the last-owner record is 0.
- R2: The grant vector is all zero when the valid flag is low. Otherwise it has exactly one bit set, at the position given by the owner index.
- R3: While an access is in progress, the owner and the valid flag do not change until the cycle after the end-of-access strobe.
- R4: When arbitration picks among requesters, the winner is the first requesting index found counting upward, with wraparound, starting one past the last owner. The grant appears one clock after the request (or after the strobe), and that master becomes the last owner.
- R5: With policy code 0 (none), or the reserved code 3, an idle port with no request has its valid flag low from the next clock.
- R6: With policy code 1 (last access), an idle port with no request stays granted to the last owner.
- R7: With policy code 2 (fixed), an idle port with no request is granted to the configured fixed master index.
- R8: With policy code 2 and a fixed index of 5, 6 or 7, the port behaves as under policy none.
- R9: If the port is idle and parked on a master that raises its request, that master keeps the grant and the owner output does not change, even when others also request.
- R10: A configuration write (policy in a 2-bit field, fixed index in a 3-bit field) takes effect from the clock edge that captures it. Without a write, both fields hold.
- R11: An end-of-access strobe while no access is in progress has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 5 | Request line per master |
| xfer_done | input | 1 | End-of-access strobe from the slave side |
| cfg_we | input | 1 | Configuration write enable |
| cfg_policy | input | 2 | Parking policy written on cfg_we (0 none, 1 last, 2 fixed, 3 reserved) |
| cfg_fixed | input | 3 | Fixed parking master index written on cfg_we |
| grant | output | 5 | One-hot grant vector |
| owner | output | 3 | Encoded index of the granted master |
| grant_valid | output | 1 | High when some master is connected |

## Verification
The bench targets the wraparound of the round-robin search past the highest index. A design that gets it wrong would starve the low masters or grant the previous owner twice in a row. It also hits out-of-range fixed indices and the reserved policy code; a faulty design would park on an absent master or keep the port connected. Two more cases are strobes that arrive while idle, which a broken design would turn into a spurious re-arbitration, and a parked master that requests while others also do. There a faulty design would move the grant away and cost that master an extra cycle.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;
   typedef enum logic [1:0] {
      PARK_NONE  = 2'd0,
      PARK_LAST  = 2'd1,
      PARK_FIXED = 2'd2,
      PARK_RSVD  = 2'd3
   } park_policy_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N_MASTERS = 5,
   parameter int IDX_W     = 3
) (
   input  logic [N_MASTERS-1:0] req,
   input  logic [IDX_W-1:0]     ptr,
   output logic                 any,
   output logic [IDX_W-1:0]     win
);
   initial begin
      if (N_MASTERS < 2 || N_MASTERS > (1 << IDX_W))
         $error("rr_pick: N_MASTERS does not fit IDX_W");
   end

   always_comb begin
      int t;
      any = 1'b0;
      win = '0;
      for (int k = 1; k <= N_MASTERS; k++) begin
         t = int'(ptr) + k;
         if (t >= N_MASTERS) t = t - N_MASTERS;
         if (!any && req[t]) begin
            any = 1'b1;
            win = IDX_W'(t);
         end
      end
   end
endmodule

// File: rtl/park_select.sv
module park_select
   import park_arb_pkg::*;
#(
   parameter int N_MASTERS = 5,
   parameter int IDX_W     = 3
) (
   input  park_policy_e     policy,
   input  logic [IDX_W-1:0] fixed_idx,
   input  logic [IDX_W-1:0] last_idx,
   output logic             park_valid,
   output logic [IDX_W-1:0] park_idx
);
   localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(N_MASTERS - 1);

   always_comb begin
      park_valid = 1'b0;
      park_idx   = last_idx;
      unique case (policy)
         PARK_LAST: park_valid = 1'b1;
         PARK_FIXED: begin
            park_idx   = fixed_idx;
            park_valid = (fixed_idx <= MAX_IDX);
         end
         default: park_valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/park_arbiter.sv
module park_arbiter
   import park_arb_pkg::*;
#(
   parameter int N_MASTERS = 5,
   parameter int IDX_W     = 3,
   parameter int POL_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req,
   input  logic                 xfer_done,
   input  logic                 cfg_we,
   input  logic [POL_W-1:0]     cfg_policy,
   input  logic [IDX_W-1:0]     cfg_fixed,
   output logic [N_MASTERS-1:0] grant,
   output logic [IDX_W-1:0]     owner,
   output logic                 grant_valid
);
   localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(N_MASTERS - 1);

   initial begin
      if (POL_W != 2) $error("park_arbiter: POL_W must be 2");
      if (N_MASTERS < 2 || N_MASTERS > (1 << IDX_W))
         $error("park_arbiter: N_MASTERS does not fit IDX_W");
   end

   park_policy_e     policy_q;
   logic [IDX_W-1:0] fixed_q, last_q, owner_q, owner_n, last_n, win;
   logic             valid_q, valid_n, busy_q, busy_n, rr_any;
   logic             park_valid;
   logic [IDX_W-1:0] park_idx;

   rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
      .req(req), .ptr(last_q), .any(rr_any), .win(win)
   );

   park_select #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_park (
      .policy(policy_q), .fixed_idx(fixed_q), .last_idx(last_q),
      .park_valid(park_valid), .park_idx(park_idx)
   );

   always_comb begin
      owner_n = owner_q;
      valid_n = valid_q;
      busy_n  = busy_q;
      last_n  = last_q;
      if (!busy_q || xfer_done) begin
         if (rr_any) begin
            if (!busy_q && valid_q && req[owner_q]) owner_n = owner_q;
            else                                    owner_n = win;
            valid_n = 1'b1;
            busy_n  = 1'b1;
            last_n  = owner_n;
         end else begin
            owner_n = park_valid ? park_idx : owner_q;
            valid_n = park_valid;
            busy_n  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         policy_q <= PARK_NONE;
         fixed_q  <= '0;
         last_q   <= '0;
         owner_q  <= '0;
         valid_q  <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         if (cfg_we) begin
            policy_q <= park_policy_e'(cfg_policy);
            fixed_q  <= cfg_fixed;
         end
         owner_q <= owner_n;
         valid_q <= valid_n;
         busy_q  <= busy_n;
         last_q  <= last_n;
      end
   end

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
      assign grant[g] = valid_q && (owner_q == IDX_W'(g));
   end
   assign owner       = owner_q;
   assign grant_valid = valid_q;

   wire idle_end = (!busy_q || xfer_done) && !(|req);

   AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid ? $onehot(grant) && grant[owner] : grant == '0)); // R2
   AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !xfer_done |=> grant_valid && $stable(owner)); // R3
   AST_PARK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_end && (policy_q == PARK_NONE || policy_q == PARK_RSVD) |=> !grant_valid); // R5
   AST_PARK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      idle_end && policy_q == PARK_LAST |=> grant_valid && owner == $past(last_q)); // R6
   AST_PARK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      idle_end && policy_q == PARK_FIXED && fixed_q <= MAX_IDX
      |=> grant_valid && owner == $past(fixed_q)); // R7
   AST_FIXED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_end && policy_q == PARK_FIXED && fixed_q > MAX_IDX |=> !grant_valid); // R8
   AST_PARKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && grant_valid && req[owner] |=> grant_valid && $stable(owner)); // R9
endmodule

// File: tb/park_arbiter_test.sv
module park_arbiter_test;
   localparam int N = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic xfer_done = 1'b0, cfg_we = 1'b0;
   logic [1:0] cfg_policy = '0;
   logic [2:0] cfg_fixed = '0;
   logic [N-1:0] grant;
   logic [2:0] owner;
   logic grant_valid;

   int checks = 0, errors = 0;
   logic done_flag = 1'b0;

   // bench model state
   int m_owner = 0, m_last = 0, m_pol = 0, m_fix = 0;
   bit m_valid = 0, m_busy = 0;
   string m_tag;

   always #4 clk = ~clk;

   park_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
      .cfg_we(cfg_we), .cfg_policy(cfg_policy), .cfg_fixed(cfg_fixed),
      .grant(grant), .owner(owner), .grant_valid(grant_valid)
   );

   function automatic int rr_win(logic [N-1:0] r, int last);
      for (int k = 1; k <= N; k++) begin
         int t = (last + k) % N;
         if (r[t]) return t;
      end
      return -1;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_step(logic [N-1:0] r, bit d, bit we, int pol, int fix);
      if (!m_busy || d) begin
         if (r != 0) begin
            if (!m_busy && m_valid && r[m_owner]) m_tag = "R9 parked master keeps grant";
            else begin
               m_owner = rr_win(r, m_last);
               m_tag = "R4 round robin";
            end
            m_valid = 1; m_busy = 1; m_last = m_owner;
         end else begin
            m_busy = 0;
            if (m_pol == 1) begin m_valid = 1; m_owner = m_last; m_tag = "R6 park last"; end
            else if (m_pol == 2 && m_fix < N) begin
               m_valid = 1; m_owner = m_fix; m_tag = "R7 park fixed";
            end else if (m_pol == 2) begin m_valid = 0; m_tag = "R8 fixed out of range"; end
            else begin m_valid = 0; m_tag = "R5 park none"; end
         end
      end else m_tag = "R3 hold during access";
      if (we) begin m_pol = pol; m_fix = fix; end
   endtask

   task automatic cycle(logic [N-1:0] r, bit d, bit we, int pol, int fix, string tag);
      req = r; xfer_done = d; cfg_we = we;
      cfg_policy = 2'(pol); cfg_fixed = 3'(fix);
      model_step(r, d, we, pol, fix);
      @(negedge clk);
      if (tag != "") m_tag = tag;
      check(m_tag, int'(grant_valid), int'(m_valid));
      if (m_valid) check(m_tag, int'(owner), m_owner);
      check("R2 grant shape", int'(grant), m_valid ? (1 << m_owner) : 0);
   endtask

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset grant", int'(grant), 0);
      check("R1 reset valid", int'(grant_valid), 0);
      // R11: strobe while idle, policy none
      cycle(5'b00000, 1, 0, 0, 0, "R11 idle strobe ignored");
      // R10: configure fixed master 3, takes effect next edge
      cycle(5'b00000, 0, 1, 2, 3, "R10 write captured");
      cycle(5'b00000, 0, 0, 0, 0, "R10 fixed park after write");
      // R9: parked master 3 plus others request
      cycle(5'b11001, 0, 0, 0, 0, "R9 parked master wins");
      cycle(5'b11001, 0, 0, 0, 0, "R3 hold");
      // R4 wraparound: last=3, requesters 0 and 4 -> 4 then 0
      cycle(5'b10001, 1, 0, 0, 0, "R4 pick after 3");
      cycle(5'b10001, 1, 0, 0, 0, "R4 wrap to 0");
      // R8: fixed index 6
      cycle(5'b00000, 1, 1, 2, 6, "");
      cycle(5'b00000, 0, 0, 0, 0, "R8 fixed 6 disconnects");
      // R5 reserved code
      cycle(5'b00000, 0, 1, 3, 1, "");
      cycle(5'b00000, 0, 0, 0, 0, "R5 reserved behaves as none");
      // R6 last policy
      cycle(5'b00100, 0, 1, 1, 0, "R4 grant master 2");
      cycle(5'b00000, 1, 0, 0, 0, "R6 stays on 2");
      // R11 strobe while parked
      cycle(5'b00000, 1, 0, 0, 0, "R11 strobe while parked");
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [N-1:0] r;
         for (int b = 0; b < N; b++) r[b] = ($urandom % 4) == 0;
         cycle(r, ($urandom % 5) < 2, ($urandom % 20) == 0,
               int'($urandom % 4), int'($urandom % 8), "");
      end
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule